// File: doc/BRIEF.md
# RV64 Base Instruction Decoder with Immediate Assembly

This block takes one 32-bit instruction word per cycle and turns it into a registered decode record. The record carries a legality flag, an operation class, a sub-operation code, the three register index fields and a fully assembled 64-bit sign-extended immediate. The encodings it accepts are the 64-bit base integer set: the upper-immediate forms, the two jumps, the six conditional branches, loads and stores of every width, the register-immediate and register-register arithmetic groups with their 32-bit word variants, the two memory-ordering fences, the environment call and breakpoint, and the atomic group (load-reserved, store-conditional and the read-modify-write operations).

The decode record appears one clock after the word is presented. Upstream fetch logic drives `in_word_i` with `in_vld_i` high. Downstream issue logic reads the record when `out_vld_o` is high. Any word that matches no accepted pattern is reported with `out_legal_o` low. The other fields of such a word carry no meaning, except the register index fields, which always mirror the word. Register-file access, execution, memory access and compressed encodings are outside this block.

Top module: `rvd_decoder`

## Requirements
- R1: The record is registered. `out_vld_o` equals `in_vld_i` of the previous cycle. After reset, `out_vld_o`, `out_legal_o` and `out_imm_o` are zero. While `in_vld_i` is low, the legality flag and register fields keep the values captured from the last presented word.
- R2: Opcode 0110111 decodes as class 0 and opcode 0010111 as class 1. For both, the immediate is word bits 31:12 followed by twelve zero bits, sign-extended from bit 31.
- R3: Opcode 1101111 decodes as class 2. Its immediate is {b31, b19:12, b20, b30:21, 0}, sign-extended from 21 bits. Opcode 1100111 decodes as class 3 only when bits 14:12 are 000, and its immediate is bits 31:20 sign-extended.
- R4: Opcode 1100011 decodes as class 4 with sub-op equal to bits 14:12. Codes 010 and 011 are illegal. The immediate is {b31, b7, b30:25, b11:8, 0}, sign-extended from 13 bits.
- R5: Opcode 0000011 decodes as class 5 with sub-op equal to bits 14:12. All codes except 111 are legal. The immediate is bits 31:20 sign-extended.
- R6: Opcode 0100011 decodes as class 6 with sub-op equal to bits 14:12. Only codes 000 to 011 are legal. The immediate is {b31:25, b11:7} sign-extended.
- R7: Opcode 0010011 decodes as class 7 with an I-type immediate. The sub-op is {bit 30, bits 14:12} for code 101 and {0, bits 14:12} otherwise. Code 001 requires bits 31:26 to be zero. Code 101 requires bits 31:26 to be 000000 or 010000. The other codes are always legal.
- R8: Opcode 0011011 decodes as class 8 with an I-type immediate. Code 000 is always legal. Code 001 requires bits 31:25 to be zero. Code 101 requires bits 31:25 to be 0000000 or 0100000, and its sub-op is {bit 30, 101}. The other codes are illegal.
- R9: Opcode 0110011 (class 9) and opcode 0111011 (class 10) have sub-op {bit 30, bits 14:12} and a zero immediate. Bits 31:25 must be 0000000, or 0100000 with code 000 or 101. Class 10 accepts only codes 000, 001 and 101.
- R10: Opcode 0001111 decodes as class 11 with an I-type immediate. Sub-op 0 requires code 000 and zero bits 31:28, 19:15 and 11:7. Sub-op 1 requires code 001 and zero bits 31:15 and 11:7.
- R11: Opcode 1110011 decodes as class 12. It is legal only when bits 31:7 are all zero (sub-op 0) or only bit 20 is set (sub-op 1).
- R12: Opcode 0101111 decodes as class 13 with sub-op {bit 12, bits 31:27} and a zero immediate. Bits 14:12 must be 010 or 011. Bits 31:27 must be one of 00000, 00001, 00010, 00011, 00100, 01000, 01100, 10000, 10100, 11000 or 11100. For 00010, bits 24:20 must be zero. `out_aq_o` carries bit 26 and `out_rl_o` carries bit 25.
- R13: Every other opcode value, including any with bits 1:0 not equal to 11, is illegal.
- R14: `out_rd_o`, `out_rs1_o` and `out_rs2_o` are word bits 11:7, 19:15 and 24:20 of every presented word, legal or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| in_vld_i | input | 1 | Instruction word present this cycle |
| in_word_i | input | 32 | Instruction word |
| out_vld_o | output | 1 | Decode record present |
| out_legal_o | output | 1 | Word matched an accepted pattern |
| out_cls_o | output | 4 | Operation class |
| out_sub_o | output | 6 | Sub-operation code |
| out_rd_o | output | 5 | Destination register index |
| out_rs1_o | output | 5 | First source register index |
| out_rs2_o | output | 5 | Second source register index |
| out_imm_o | output | 64 | Assembled sign-extended immediate |
| out_aq_o | output | 1 | Acquire ordering bit of an atomic |
| out_rl_o | output | 1 | Release ordering bit of an atomic |

## Verification
A new word can be decoded in the same cycle that the record register still holds the previous word's immediate and class. A word of a different format in the next slot must replace every field, with nothing left over from the earlier word. The bench provokes this by streaming directed and random words back to back, mixing formats, legal and illegal encodings, and idle slots. A behavioural model predicts each record, and the bench compares the record on every clock. Jump and branch words are also built from a chosen offset, and the bench checks that exact offset comes back. Idle slots check that the held fields do not move.

// File: rtl/rvd_pkg.sv
package rvd_pkg;

    localparam int XLEN = 64;
    localparam int ILEN = 32;
    localparam int SUBW = 6;
    localparam int RIDX = 5;
    localparam int CLSW = 4;

    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_ALUI   = 7'b0010011;
    localparam logic [6:0] OPC_ALUIW  = 7'b0011011;
    localparam logic [6:0] OPC_ALUR   = 7'b0110011;
    localparam logic [6:0] OPC_ALURW  = 7'b0111011;
    localparam logic [6:0] OPC_ORDER  = 7'b0001111;
    localparam logic [6:0] OPC_SYS    = 7'b1110011;
    localparam logic [6:0] OPC_ATOM   = 7'b0101111;

    typedef enum logic [CLSW-1:0] {
        CL_LUI   = 4'd0,
        CL_AUIPC = 4'd1,
        CL_JAL   = 4'd2,
        CL_JALR  = 4'd3,
        CL_BR    = 4'd4,
        CL_LD    = 4'd5,
        CL_ST    = 4'd6,
        CL_ALUI  = 4'd7,
        CL_ALUIW = 4'd8,
        CL_ALUR  = 4'd9,
        CL_ALURW = 4'd10,
        CL_ORDER = 4'd11,
        CL_SYS   = 4'd12,
        CL_ATOM  = 4'd13
    } cls_e;

    typedef enum logic [2:0] {
        FMT_Z = 3'd0,
        FMT_I = 3'd1,
        FMT_S = 3'd2,
        FMT_B = 3'd3,
        FMT_U = 3'd4,
        FMT_J = 3'd5
    } fmt_e;

    typedef struct packed {
        logic            vld;
        logic            legal;
        cls_e            cls;
        logic [SUBW-1:0] sub;
        logic [RIDX-1:0] rd;
        logic [RIDX-1:0] rs1;
        logic [RIDX-1:0] rs2;
        logic [XLEN-1:0] imm;
        logic            aq;
        logic            rl;
    } dec_s;

endpackage

// File: rtl/rvd_imm_build.sv
module rvd_imm_build
    import rvd_pkg::*;
#(
    parameter int XW = XLEN
) (
    input  logic [ILEN-1:7] word_i,
    input  fmt_e            fmt_i,
    output logic [XW-1:0]   imm_o
);

    localparam int EXT_I = XW - 12;
    localparam int EXT_B = XW - 13;
    localparam int EXT_U = XW - 32;
    localparam int EXT_J = XW - 21;

    logic sgn;
    assign sgn = word_i[31];

    always_comb begin
        imm_o = '0;
        case (fmt_i)
            FMT_I: imm_o = {{EXT_I{sgn}}, word_i[31:20]};
            FMT_S: imm_o = {{EXT_I{sgn}}, word_i[31:25], word_i[11:7]};
            FMT_B: imm_o = {{EXT_B{sgn}}, word_i[31], word_i[7], word_i[30:25],
                            word_i[11:8], 1'b0};
            FMT_U: imm_o = {{EXT_U{sgn}}, word_i[31:12], 12'b0};
            FMT_J: imm_o = {{EXT_J{sgn}}, word_i[31], word_i[19:12], word_i[20],
                            word_i[30:21], 1'b0};
            default: imm_o = '0;
        endcase
    end

endmodule

// File: rtl/rvd_field_decode.sv
module rvd_field_decode
    import rvd_pkg::*;
(
    input  logic [ILEN-1:0] word_i,
    output logic            legal_o,
    output cls_e            cls_o,
    output logic [SUBW-1:0] sub_o,
    output fmt_e            fmt_o,
    output logic            aq_o,
    output logic            rl_o
);

    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic [4:0] f5;
    logic       amo_op_ok;

    assign opc = word_i[6:0];
    assign f3  = word_i[14:12];
    assign f7  = word_i[31:25];
    assign f5  = word_i[31:27];

    always_comb begin
        case (f5)
            5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b00100, 5'b01000,
            5'b01100, 5'b10000, 5'b10100, 5'b11000, 5'b11100: amo_op_ok = 1'b1;
            default: amo_op_ok = 1'b0;
        endcase
    end

    always_comb begin
        legal_o = 1'b0;
        cls_o   = CL_LUI;
        sub_o   = '0;
        fmt_o   = FMT_Z;
        aq_o    = 1'b0;
        rl_o    = 1'b0;
        case (opc)
            OPC_LUI: begin
                legal_o = 1'b1;
                cls_o   = CL_LUI;
                fmt_o   = FMT_U;
            end
            OPC_AUIPC: begin
                legal_o = 1'b1;
                cls_o   = CL_AUIPC;
                fmt_o   = FMT_U;
            end
            OPC_JAL: begin
                legal_o = 1'b1;
                cls_o   = CL_JAL;
                fmt_o   = FMT_J;
            end
            OPC_JALR: begin
                legal_o = (f3 == 3'b000);
                cls_o   = CL_JALR;
                fmt_o   = FMT_I;
            end
            OPC_BRANCH: begin
                legal_o = (f3[2:1] != 2'b01);
                cls_o   = CL_BR;
                sub_o   = {3'b000, f3};
                fmt_o   = FMT_B;
            end
            OPC_LOAD: begin
                legal_o = (f3 != 3'b111);
                cls_o   = CL_LD;
                sub_o   = {3'b000, f3};
                fmt_o   = FMT_I;
            end
            OPC_STORE: begin
                legal_o = ~f3[2];
                cls_o   = CL_ST;
                sub_o   = {3'b000, f3};
                fmt_o   = FMT_S;
            end
            OPC_ALUI: begin
                cls_o = CL_ALUI;
                fmt_o = FMT_I;
                sub_o = {3'b000, f3};
                if (f3 == 3'b001) begin
                    legal_o = (word_i[31:26] == 6'b000000);
                end else if (f3 == 3'b101) begin
                    legal_o = (word_i[31:26] == 6'b000000) || (word_i[31:26] == 6'b010000);
                    sub_o   = {2'b00, word_i[30], f3};
                end else begin
                    legal_o = 1'b1;
                end
            end
            OPC_ALUIW: begin
                cls_o = CL_ALUIW;
                fmt_o = FMT_I;
                sub_o = {3'b000, f3};
                case (f3)
                    3'b000: legal_o = 1'b1;
                    3'b001: legal_o = (f7 == 7'b0000000);
                    3'b101: begin
                        legal_o = (f7 == 7'b0000000) || (f7 == 7'b0100000);
                        sub_o   = {2'b00, word_i[30], f3};
                    end
                    default: legal_o = 1'b0;
                endcase
            end
            OPC_ALUR, OPC_ALURW: begin
                cls_o = (opc == OPC_ALUR) ? CL_ALUR : CL_ALURW;
                fmt_o = FMT_Z;
                sub_o = {2'b00, word_i[30], f3};
                if (f7 == 7'b0000000) begin
                    legal_o = 1'b1;
                end else if (f7 == 7'b0100000) begin
                    legal_o = (f3 == 3'b000) || (f3 == 3'b101);
                end else begin
                    legal_o = 1'b0;
                end
                if (opc == OPC_ALURW && !(f3 == 3'b000 || f3 == 3'b001 || f3 == 3'b101)) begin
                    legal_o = 1'b0;
                end
            end
            OPC_ORDER: begin
                cls_o = CL_ORDER;
                fmt_o = FMT_I;
                if (f3 == 3'b000) begin
                    sub_o   = 6'd0;
                    legal_o = (word_i[31:28] == 4'b0) && (word_i[19:15] == 5'b0) &&
                              (word_i[11:7] == 5'b0);
                end else if (f3 == 3'b001) begin
                    sub_o   = 6'd1;
                    legal_o = (word_i[31:15] == 17'b0) && (word_i[11:7] == 5'b0);
                end else begin
                    legal_o = 1'b0;
                end
            end
            OPC_SYS: begin
                cls_o = CL_SYS;
                fmt_o = FMT_I;
                if (word_i[31:7] == 25'h0000000) begin
                    legal_o = 1'b1;
                    sub_o   = 6'd0;
                end else if (word_i[31:7] == 25'h0002000) begin
                    legal_o = 1'b1;
                    sub_o   = 6'd1;
                end else begin
                    legal_o = 1'b0;
                end
            end
            OPC_ATOM: begin
                cls_o   = CL_ATOM;
                fmt_o   = FMT_Z;
                sub_o   = {word_i[12], f5};
                aq_o    = word_i[26];
                rl_o    = word_i[25];
                legal_o = amo_op_ok && (f3[2:1] == 2'b01) &&
                          !((f5 == 5'b00010) && (word_i[24:20] != 5'b0));
            end
            default: legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rvd_decoder.sv
module rvd_decoder
    import rvd_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            in_vld_i,
    input  logic [31:0]     in_word_i,
    output logic            out_vld_o,
    output logic            out_legal_o,
    output logic [3:0]      out_cls_o,
    output logic [5:0]      out_sub_o,
    output logic [4:0]      out_rd_o,
    output logic [4:0]      out_rs1_o,
    output logic [4:0]      out_rs2_o,
    output logic [63:0]     out_imm_o,
    output logic            out_aq_o,
    output logic            out_rl_o
);

    logic            legal;
    cls_e            cls;
    logic [SUBW-1:0] sub;
    fmt_e            fmt;
    logic            aq;
    logic            rl;
    logic [XLEN-1:0] imm;

    dec_s rec_d, rec_q;

    rvd_field_decode u_field (
        .word_i  (in_word_i),
        .legal_o (legal),
        .cls_o   (cls),
        .sub_o   (sub),
        .fmt_o   (fmt),
        .aq_o    (aq),
        .rl_o    (rl)
    );

    rvd_imm_build #(.XW(XLEN)) u_imm (
        .word_i (in_word_i[ILEN-1:7]),
        .fmt_i  (fmt),
        .imm_o  (imm)
    );

    always_comb begin
        rec_d     = rec_q;
        rec_d.vld = in_vld_i;
        if (in_vld_i) begin
            rec_d.legal = legal;
            rec_d.cls   = cls;
            rec_d.sub   = sub;
            rec_d.rd    = in_word_i[11:7];
            rec_d.rs1   = in_word_i[19:15];
            rec_d.rs2   = in_word_i[24:20];
            rec_d.imm   = imm;
            rec_d.aq    = aq;
            rec_d.rl    = rl;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    assign out_vld_o   = rec_q.vld;
    assign out_legal_o = rec_q.legal;
    assign out_cls_o   = rec_q.cls;
    assign out_sub_o   = rec_q.sub;
    assign out_rd_o    = rec_q.rd;
    assign out_rs1_o   = rec_q.rs1;
    assign out_rs2_o   = rec_q.rs2;
    assign out_imm_o   = rec_q.imm;
    assign out_aq_o    = rec_q.aq;
    assign out_rl_o    = rec_q.rl;

endmodule

// File: rtl/rvd_decoder_chk.sv
module rvd_decoder_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        in_vld_i,
    input logic [24:0] word_lo_i,
    input logic        out_vld_o,
    input logic        out_legal_o,
    input logic [3:0]  out_cls_o,
    input logic [5:0]  out_sub_o,
    input logic [4:0]  out_rd_o,
    input logic [4:0]  out_rs1_o,
    input logic [4:0]  out_rs2_o,
    input logic [63:0] out_imm_o
);

    logic rec_ok;
    assign rec_ok = out_vld_o && out_legal_o;

    // R1: record follows the input strobe by one cycle
    p_vld_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_vld_i |=> out_vld_o);
    p_vld_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_vld_i |=> !out_vld_o);

    // R14: register index fields mirror the presented word
    p_reg_fields_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_vld_i |=> (out_rd_o == $past(word_lo_i[11:7])) &&
                     (out_rs1_o == $past(word_lo_i[19:15])) &&
                     (out_rs2_o == $past(word_lo_i[24:20])));

    // R2: upper-immediate forms have twelve clear low bits
    p_upper_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rec_ok && (out_cls_o == 4'd0 || out_cls_o == 4'd1) |-> out_imm_o[11:0] == 12'h000);

    // R3: jump offset is even and sign-extended from 21 bits
    p_jal_shape_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rec_ok && out_cls_o == 4'd2 |->
            !out_imm_o[0] && (out_imm_o[63:20] == '0 || out_imm_o[63:20] == '1));

    // R4: branch offset is even and sign-extended from 13 bits
    p_br_shape_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rec_ok && out_cls_o == 4'd4 |->
            !out_imm_o[0] && (out_imm_o[63:12] == '0 || out_imm_o[63:12] == '1));

    // R4: reserved branch conditions are rejected
    p_br_reserved_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_vld_i && word_lo_i[6:0] == 7'b1100011 && word_lo_i[14:13] == 2'b01
            |=> !out_legal_o);

    // R9: register-register forms carry no immediate
    p_rr_noimm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rec_ok && (out_cls_o == 4'd9 || out_cls_o == 4'd10) |-> out_imm_o == 64'd0);

    // R12: load-reserved never reports a second source
    p_lr_rs2_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rec_ok && out_cls_o == 4'd13 && (out_sub_o == 6'b000010 || out_sub_o == 6'b100010)
            |-> out_rs2_o == 5'd0);

endmodule

bind rvd_decoder rvd_decoder_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_vld_i    (in_vld_i),
    .word_lo_i   (in_word_i[24:0]),
    .out_vld_o   (out_vld_o),
    .out_legal_o (out_legal_o),
    .out_cls_o   (out_cls_o),
    .out_sub_o   (out_sub_o),
    .out_rd_o    (out_rd_o),
    .out_rs1_o   (out_rs1_o),
    .out_rs2_o   (out_rs2_o),
    .out_imm_o   (out_imm_o)
);

// File: tb/rvd_decoder_tb.sv
`timescale 1ns/1ps
module rvd_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] in_word = 32'd0;
    logic        out_vld, out_legal, out_aq, out_rl;
    logic [3:0]  out_cls;
    logic [5:0]  out_sub;
    logic [4:0]  out_rd, out_rs1, out_rs2;
    logic [63:0] out_imm;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rvd_decoder u_dut (
        .clk_i(clk), .rst_ni(rst_n), .in_vld_i(in_vld), .in_word_i(in_word),
        .out_vld_o(out_vld), .out_legal_o(out_legal), .out_cls_o(out_cls),
        .out_sub_o(out_sub), .out_rd_o(out_rd), .out_rs1_o(out_rs1),
        .out_rs2_o(out_rs2), .out_imm_o(out_imm), .out_aq_o(out_aq), .out_rl_o(out_rl)
    );

    typedef struct {
        bit          vld;
        bit          ok;
        logic [3:0]  c;
        logic [5:0]  s;
        logic [63:0] im;
        bit          aq;
        bit          rl;
        logic [4:0]  rd, rs1, rs2;
        bit          has_off;
        logic [63:0] off;
        string       tag;
    } exp_t;

    exp_t pend[$];
    bit         hold_ok = 1'b0;
    logic [4:0] hold_rd = 5'd0, hold_rs1 = 5'd0, hold_rs2 = 5'd0;

    function automatic logic [63:0] sx(input logic [63:0] v, input int bits);
        logic [63:0] m;
        m = 64'd1 << (bits - 1);
        return (v ^ m) - m;
    endfunction

    // behavioural model of the decode rules
    function automatic exp_t model(input logic [31:0] w);
        exp_t e;
        logic [2:0] f3;
        logic [6:0] f7;
        logic [4:0] f5;
        logic [63:0] i_imm;
        f3 = w[14:12]; f7 = w[31:25]; f5 = w[31:27];
        i_imm = sx({52'd0, w[31:20]}, 12);
        e.vld = 1; e.ok = 0; e.c = 0; e.s = 0; e.im = 0; e.aq = 0; e.rl = 0;
        e.rd = w[11:7]; e.rs1 = w[19:15]; e.rs2 = w[24:20]; e.has_off = 0; e.off = 0;
        e.tag = "";
        case (w[6:0])
            7'h37, 7'h17: begin
                e.ok = 1; e.c = (w[6:0] == 7'h37) ? 4'd0 : 4'd1;
                e.im = sx({32'd0, w[31:12], 12'd0}, 32);
            end
            7'h6F: begin
                e.ok = 1; e.c = 2;
                e.im = sx({43'd0, w[31], w[19:12], w[20], w[30:21], 1'b0}, 21);
            end
            7'h67: begin e.ok = (f3 == 0); e.c = 3; e.im = i_imm; end
            7'h63: begin
                e.ok = !(f3 == 2 || f3 == 3); e.c = 4; e.s = {3'd0, f3};
                e.im = sx({51'd0, w[31], w[7], w[30:25], w[11:8], 1'b0}, 13);
            end
            7'h03: begin e.ok = (f3 != 7); e.c = 5; e.s = {3'd0, f3}; e.im = i_imm; end
            7'h23: begin
                e.ok = (f3 < 4); e.c = 6; e.s = {3'd0, f3};
                e.im = sx({52'd0, w[31:25], w[11:7]}, 12);
            end
            7'h13: begin
                e.c = 7; e.im = i_imm; e.s = {3'd0, f3}; e.ok = 1;
                if (f3 == 1) e.ok = (w[31:26] == 0);
                if (f3 == 5) begin
                    e.ok = (w[31:26] == 0) || (w[31:26] == 6'h10);
                    e.s = {2'd0, w[30], f3};
                end
            end
            7'h1B: begin
                e.c = 8; e.im = i_imm; e.s = {3'd0, f3};
                if (f3 == 0) e.ok = 1;
                else if (f3 == 1) e.ok = (f7 == 0);
                else if (f3 == 5) begin
                    e.ok = (f7 == 0) || (f7 == 7'h20); e.s = {2'd0, w[30], f3};
                end
            end
            7'h33, 7'h3B: begin
                e.c = (w[6:0] == 7'h33) ? 4'd9 : 4'd10;
                e.s = {2'd0, w[30], f3};
                e.ok = (f7 == 0) || (f7 == 7'h20 && (f3 == 0 || f3 == 5));
                if (e.c == 10 && !(f3 == 0 || f3 == 1 || f3 == 5)) e.ok = 0;
            end
            7'h0F: begin
                e.c = 11; e.im = i_imm;
                if (f3 == 0) begin
                    e.s = 0; e.ok = (w[31:28] == 0) && (w[19:15] == 0) && (w[11:7] == 0);
                end else if (f3 == 1) begin
                    e.s = 1; e.ok = (w[31:15] == 0) && (w[11:7] == 0);
                end
            end
            7'h73: begin
                e.c = 12; e.im = i_imm;
                if (w[31:7] == 0) begin e.ok = 1; e.s = 0; end
                else if (w[31:7] == (25'd1 << 13)) begin e.ok = 1; e.s = 1; end
            end
            7'h2F: begin
                e.c = 13; e.s = {w[12], f5}; e.aq = w[26]; e.rl = w[25];
                e.ok = (f3 == 2 || f3 == 3) &&
                       (f5 inside {5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h08,
                                   5'h0C, 5'h10, 5'h14, 5'h18, 5'h1C}) &&
                       !(f5 == 5'h02 && w[24:20] != 0);
            end
            default: e.ok = 0;
        endcase
        return e;
    endfunction

    task automatic check_head();
        exp_t e;
        if (pend.size() == 0) return;
        e = pend.pop_front();
        tests++;
        if (out_vld !== e.vld) begin
            fails++;
            $display("FAIL %s R1 out_vld act=%0b exp=%0b", e.tag, out_vld, e.vld);
        end
        if (!e.vld) begin
            // R1: idle slot leaves the held fields untouched
            tests++;
            if (out_legal !== hold_ok || out_rd !== hold_rd || out_rs1 !== hold_rs1 ||
                out_rs2 !== hold_rs2) begin
                fails++;
                $display("FAIL R1 hold act=%0b/%0d/%0d/%0d exp=%0b/%0d/%0d/%0d",
                         out_legal, out_rd, out_rs1, out_rs2,
                         hold_ok, hold_rd, hold_rs1, hold_rs2);
            end
            return;
        end
        hold_ok = e.ok; hold_rd = e.rd; hold_rs1 = e.rs1; hold_rs2 = e.rs2;
        tests++;
        if (out_legal !== e.ok || out_rd !== e.rd || out_rs1 !== e.rs1 || out_rs2 !== e.rs2) begin
            fails++;
            $display("FAIL %s R14 legal/rd/rs1/rs2 act=%0b/%0d/%0d/%0d exp=%0b/%0d/%0d/%0d",
                     e.tag, out_legal, out_rd, out_rs1, out_rs2, e.ok, e.rd, e.rs1, e.rs2);
        end
        if (e.ok) begin
            tests++;
            if (out_cls !== e.c || out_sub !== e.s || out_imm !== e.im ||
                (e.c == 13 && (out_aq !== e.aq || out_rl !== e.rl))) begin
                fails++;
                $display("FAIL %s cls/sub/imm/aq/rl act=%0d/%h/%h/%0b%0b exp=%0d/%h/%h/%0b%0b",
                         e.tag, out_cls, out_sub, out_imm, out_aq, out_rl,
                         e.c, e.s, e.im, e.aq, e.rl);
            end
        end
        if (e.has_off) begin
            tests++;
            if (out_imm !== e.off) begin
                fails++;
                $display("FAIL %s offset round trip act=%h exp=%h", e.tag, out_imm, e.off);
            end
        end
    endtask

    task automatic send(input logic [31:0] w, input bit v, input string tag);
        exp_t e;
        @(negedge clk);
        check_head();
        in_word = w; in_vld = v;
        e = model(w);
        e.vld = v; e.tag = tag;
        pend.push_back(e);
    endtask

    task automatic send_off(input logic [31:0] w, input logic [63:0] off, input string tag);
        exp_t e;
        @(negedge clk);
        check_head();
        in_word = w; in_vld = 1'b1;
        e = model(w);
        e.tag = tag; e.has_off = 1; e.off = off;
        pend.push_back(e);
    endtask

    function automatic logic [31:0] enc_j(input logic [20:0] o, input logic [4:0] rd);
        return {o[20], o[10:1], o[11], o[19:12], rd, 7'h6F};
    endfunction

    function automatic logic [31:0] enc_b(input logic [12:0] o, input logic [2:0] f3);
        return {o[12], o[10:5], 5'd6, 5'd9, f3, o[4:1], o[11], 7'h63};
    endfunction

    initial begin : watchdog
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [6:0] opcs [14];
        opcs = '{7'h37, 7'h17, 7'h6F, 7'h67, 7'h63, 7'h03, 7'h23,
                 7'h13, 7'h1B, 7'h33, 7'h3B, 7'h0F, 7'h73, 7'h2F};
        in_word = 32'hFFFF_FFFF; in_vld = 1'b1;
        repeat (3) @(negedge clk);
        tests++;
        if (out_vld !== 1'b0 || out_legal !== 1'b0 || out_imm !== 64'd0) begin
            fails++;
            $display("FAIL R1 reset act=%0b/%0b/%h exp=0/0/0", out_vld, out_legal, out_imm);
        end
        in_vld = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // upper immediates
        send({20'h80000, 5'd5, 7'h37}, 1, "R2");
        send({20'h12345, 5'd6, 7'h17}, 1, "R2");
        send({20'h7FFFF, 5'd1, 7'h37}, 1, "R2");
        // jumps with chosen offsets
        send_off(enc_j(21'h1FF800, 5'd1), 64'hFFFF_FFFF_FFFF_F800, "R3");
        send_off(enc_j(21'h0ABCDE, 5'd2), 64'h0000_0000_000A_BCDE, "R3");
        send_off(enc_j(21'h100000, 5'd0), 64'hFFFF_FFFF_FFF0_0000, "R3");
        send({12'h801, 5'd3, 3'd0, 5'd1, 7'h67}, 1, "R3");
        send({12'h801, 5'd3, 3'd1, 5'd1, 7'h67}, 1, "R3");
        // branches, every condition code
        for (int f = 0; f < 8; f++)
            send_off(enc_b(13'h1FFE, 3'(f)), 64'hFFFF_FFFF_FFFF_FFFE, "R4");
        send_off(enc_b(13'h0FFE, 3'd0), 64'h0000_0000_0000_0FFE, "R4");
        send_off(enc_b(13'h1000, 3'd1), 64'hFFFF_FFFF_FFFF_F000, "R4");
        // loads and stores
        for (int f = 0; f < 8; f++) send({12'hF80, 5'd2, 3'(f), 5'd7, 7'h03}, 1, "R5");
        for (int f = 0; f < 8; f++) send({7'h40, 5'd8, 5'd2, 3'(f), 5'h1F, 7'h23}, 1, "R6");
        // register-immediate, including shift variants
        for (int f = 0; f < 8; f++) send({12'h823, 5'd4, 3'(f), 5'd4, 7'h13}, 1, "R7");
        send({6'h00, 6'h3F, 5'd4, 3'd1, 5'd4, 7'h13}, 1, "R7");
        send({6'h10, 6'h21, 5'd4, 3'd5, 5'd4, 7'h13}, 1, "R7");
        send({6'h00, 6'h21, 5'd4, 3'd5, 5'd4, 7'h13}, 1, "R7");
        send({6'h10, 6'h01, 5'd4, 3'd1, 5'd4, 7'h13}, 1, "R7");
        for (int f = 0; f < 8; f++) send({7'h00, 5'd3, 5'd4, 3'(f), 5'd4, 7'h1B}, 1, "R8");
        send({7'h20, 5'd3, 5'd4, 3'd5, 5'd4, 7'h1B}, 1, "R8");
        send({7'h01, 5'd3, 5'd4, 3'd1, 5'd4, 7'h1B}, 1, "R8");
        send({7'h7F, 5'd3, 5'd4, 3'd0, 5'd4, 7'h1B}, 1, "R8");
        // register-register
        for (int f = 0; f < 8; f++) begin
            send({7'h00, 5'd11, 5'd12, 3'(f), 5'd13, 7'h33}, 1, "R9");
            send({7'h20, 5'd11, 5'd12, 3'(f), 5'd13, 7'h33}, 1, "R9");
            send({7'h01, 5'd11, 5'd12, 3'(f), 5'd13, 7'h33}, 1, "R9");
            send({7'h00, 5'd11, 5'd12, 3'(f), 5'd13, 7'h3B}, 1, "R9");
            send({7'h20, 5'd11, 5'd12, 3'(f), 5'd13, 7'h3B}, 1, "R9");
        end
        // ordering
        send({4'h0, 4'h3, 4'h3, 5'd0, 3'd0, 5'd0, 7'h0F}, 1, "R10");
        send({4'h0, 4'h3, 4'h3, 5'd0, 3'd0, 5'd1, 7'h0F}, 1, "R10");
        send({4'h8, 4'h3, 4'h3, 5'd0, 3'd0, 5'd0, 7'h0F}, 1, "R10");
        send({12'h000, 5'd0, 3'd1, 5'd0, 7'h0F}, 1, "R10");
        send({12'h001, 5'd0, 3'd1, 5'd0, 7'h0F}, 1, "R10");
        send({12'h000, 5'd0, 3'd2, 5'd0, 7'h0F}, 1, "R10");
        // environment call / breakpoint
        send(32'h0000_0073, 1, "R11");
        send(32'h0010_0073, 1, "R11");
        send(32'h0020_0073, 1, "R11");
        send(32'h0000_00F3, 1, "R11");
        // atomics
        for (int f5 = 0; f5 < 32; f5++) begin
            for (int f3 = 1; f3 < 4; f3++) begin
                send({5'(f5), 1'(f5 & 1), 1'(f3 & 1), (f5 == 2) ? 5'd0 : 5'd9,
                      5'd10, 3'(f3), 5'd11, 7'h2F}, 1, "R12");
            end
        end
        send({5'h02, 2'b10, 5'd3, 5'd10, 3'd2, 5'd11, 7'h2F}, 1, "R12");
        send({5'h02, 2'b01, 5'd0, 5'd10, 3'd3, 5'd11, 7'h2F}, 1, "R12");
        // every opcode value, then idle slots between words
        for (int o = 0; o < 128; o++) send({25'h0A5A5A5, 7'(o)}, 1, "R13");
        send(32'h1234_5678, 0, "R1");
        send(32'h0000_0000, 0, "R1");
        send({12'h7FF, 5'd21, 3'd0, 5'd22, 7'h13}, 1, "R14");
        send({12'hFFF, 5'd31, 3'd7, 5'd31, 7'h03}, 0, "R1");
        // mixed random stream
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] w;
            int sel;
            w = $urandom;
            sel = $urandom_range(0, 7);
            if (sel < 6) w[6:0] = opcs[$urandom_range(0, 13)];
            send(w, sel != 7, "R13");
        end
        send(32'd0, 0, "R1");
        @(negedge clk);
        check_head();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule